// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts the fetch target of return-type control transfers: subroutine returns, coroutine jumps and returns from exception. Every call pushes only the instruction-cache index of its return address onto a short circular stack. When a return-type instruction is fetched, the block pops that index and builds the full predicted PC. The upper address bits come from the instruction-cache tag array entry at that index, and the lowest bits are zero because the prediction points at the start of a cache block.

The tag array is a behavioural memory that is filled through a write port. Prediction is switched off entirely while the core runs privileged firmware. In that mode the stack is also left untouched. As a result, no overflow, underflow or stale entry can ever produce a prediction that reaches privileged code. A resolution port compares the most recent prediction with the actual target and raises a mispredict flag for one cycle.

Top module: `ras_predictor`

## Requirements
- R1: After reset, pred_valid and mispredict are 0, and every stack slot holds index 0. A return in the first cycle after reset therefore predicts {tag[0], 8'd0, 5'd0}.
- R2: When ret_valid is 1 and priv_mode is 0, pred_valid is 1 in the same cycle. pred_pc is then {tag[i], i, 5'b00000}, where i is the index on top of the stack. This holds for every ret_kind: 0 = return, 1 = coroutine jump, 2 = return from exception, 3 = treated as return.
- R3: A call with priv_mode 0 pushes link_pc[12:5]. Successive returns pop these indices in last-in, first-out order.
- R4: The stack has 12 slots and is circular. A push onto a full stack overwrites the oldest slot. A pop from an empty stack returns whatever stale slot lies below, with no error.
- R5: A coroutine jump (ret_kind 1) predicts from the current top. It then replaces that top with link_pc[12:5], so stack depth is unchanged.
- R6: When a call and a return arrive in the same cycle, the pop is applied first. The prediction uses the old top, the call's index becomes the new top, and depth is unchanged.
- R7: While priv_mode is 1, pred_valid stays 0. Calls and returns in that mode leave the stack contents and depth unchanged.
- R8: res_valid in cycle t sets mispredict in cycle t+1. It is set if the last return seen before t+1 made no prediction, or if that prediction differs from res_pc. Otherwise mispredict is 0, and it is 0 in any cycle that does not follow a resolution.
- R9: A return fetched in privileged mode is always reported as mispredicted when it is resolved, whatever res_pc is.
- R10: tag_we writes tag_data into tag entry tag_idx at the clock edge. Predictions from the next cycle on use the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_mode | input | 1 | Core is in privileged firmware mode |
| call_valid | input | 1 | A call is fetched this cycle |
| ret_valid | input | 1 | A return-type instruction is fetched this cycle |
| ret_kind | input | 2 | 0 return, 1 coroutine jump, 2 return from exception, 3 return |
| link_pc | input | 43 | Return address of the call or coroutine jump |
| pred_valid | output | 1 | pred_pc holds a stack prediction |
| pred_pc | output | 43 | Predicted target PC |
| res_valid | input | 1 | Actual target of the last return is known |
| res_pc | input | 43 | Actual target PC |
| mispredict | output | 1 | Last resolution did not match the prediction |
| tag_we | input | 1 | Tag array write enable |
| tag_idx | input | 8 | Tag array write index |
| tag_data | input | 30 | Upper PC bits to store |

## Verification
Several properties are checked on every cycle. No prediction appears in privileged mode, and the stack pointer never moves there. Predicted PCs are always block aligned. The pointer stays inside the 12 slots. Paired pop and push operations keep the depth unchanged, and a mispredict only ever follows a resolution. Only the bench scenarios can show the values themselves: last-in, first-out order across every depth from 1 to 12, the oldest-entry overwrite and the stale underflow value, coroutine replacement, the same-cycle pop-before-push order, tag rewrites reaching later predictions, and correct comparison of matching and mismatching resolutions.

// File: rtl/ras_predictor.sv
module ras_predictor #(
  parameter int PC_W   = 43,
  parameter int IDX_LO = 5,
  parameter int IDX_W  = 8,
  parameter int DEPTH  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            priv_mode,
  input  logic            call_valid,
  input  logic            ret_valid,
  input  logic [1:0]      ret_kind,
  input  logic [PC_W-1:0] link_pc,
  output logic            pred_valid,
  output logic [PC_W-1:0] pred_pc,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  output logic            mispredict,
  input  logic            tag_we,
  input  logic [IDX_W-1:0] tag_idx,
  input  logic [PC_W-IDX_LO-IDX_W-1:0] tag_data
);
  localparam int TAG_W = PC_W - IDX_LO - IDX_W;
  localparam int SP_W  = $clog2(DEPTH);
  localparam int SETS  = 1 << IDX_W;
  localparam logic [SP_W-1:0] LAST = SP_W'(DEPTH - 1);
  localparam logic [1:0] KIND_CORO = 2'd1;

  logic [IDX_W-1:0] stk [DEPTH];
  logic [TAG_W-1:0] tags [SETS];
  logic [SP_W-1:0]  sp;
  logic             held_v;
  logic [PC_W-1:0]  held_pc;

  wire [SP_W-1:0]  top      = (sp == '0) ? LAST : sp - 1'b1;
  wire             active   = ~priv_mode;
  wire             do_pop   = ret_valid & active;
  wire             do_push  = (call_valid | (ret_valid & (ret_kind == KIND_CORO))) & active;
  wire [SP_W-1:0]  base     = do_pop ? top : sp;
  wire [SP_W-1:0]  base_inc = (base == LAST) ? '0 : base + 1'b1;
  wire [IDX_W-1:0] top_idx  = stk[top];
  wire [IDX_W-1:0] link_idx = link_pc[IDX_LO+IDX_W-1:IDX_LO];

  assign pred_valid = do_pop;
  assign pred_pc    = {tags[top_idx], top_idx, {IDX_LO{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp <= '0;
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else if (do_push) begin
      stk[base] <= link_idx;
      sp        <= base_inc;
    end else begin
      sp <= base;
    end
  end

  always_ff @(posedge clk) begin
    if (tag_we) tags[tag_idx] <= tag_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_v     <= 1'b0;
      held_pc    <= '0;
      mispredict <= 1'b0;
    end else begin
      mispredict <= res_valid & (~held_v | (held_pc != res_pc));
      if (ret_valid) begin
        held_v  <= active;
        held_pc <= pred_pc;
      end
    end
  end
endmodule

module ras_predictor_props #(
  parameter int PC_W   = 43,
  parameter int IDX_LO = 5,
  parameter int DEPTH  = 12,
  parameter int SP_W   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            priv_mode,
  input logic            call_valid,
  input logic            ret_valid,
  input logic [1:0]      ret_kind,
  input logic            pred_valid,
  input logic [PC_W-1:0] pred_pc,
  input logic            res_valid,
  input logic            mispredict,
  input logic [SP_W-1:0] sp
);
  assert_no_pred_in_priv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    priv_mode |-> !pred_valid);
  assert_frozen_in_priv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    priv_mode |=> $stable(sp));
  assert_block_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> (pred_pc[IDX_LO-1:0] == '0));
  assert_sp_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sp < SP_W'(DEPTH));
  assert_coro_keeps_depth_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv_mode && ret_valid && ret_kind == 2'd1) |=> $stable(sp));
  assert_pair_keeps_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!priv_mode && ret_valid && call_valid) |=> $stable(sp));
  assert_mispredict_after_res_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> $past(res_valid));
  assert_priv_ret_mispredicts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && priv_mode) ##1 res_valid |=> mispredict);
endmodule

bind ras_predictor ras_predictor_props #(.PC_W(PC_W), .IDX_LO(IDX_LO), .DEPTH(DEPTH), .SP_W(SP_W)) u_props (
  .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode), .call_valid(call_valid),
  .ret_valid(ret_valid), .ret_kind(ret_kind), .pred_valid(pred_valid),
  .pred_pc(pred_pc), .res_valid(res_valid), .mispredict(mispredict), .sp(sp)
);

// File: tb/test_ras_predictor.sv
module test_ras_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        priv_mode = 1'b0, call_valid = 1'b0, ret_valid = 1'b0, res_valid = 1'b0, tag_we = 1'b0;
  logic [1:0]  ret_kind = 2'd0;
  logic [42:0] link_pc = '0, res_pc = '0;
  logic [7:0]  tag_idx = '0;
  logic [29:0] tag_data = '0;
  logic        pred_valid, mispredict;
  logic [42:0] pred_pc;

  int checks = 0, errors = 0;
  logic [29:0] ttag [256];
  logic [7:0]  mstk [12];
  int          msp = 0;
  logic        hv = 1'b0;
  logic [42:0] hpc = '0;
  logic [42:0] last_exp = '0;

  always #2 clk = ~clk;

  ras_predictor i_ras_predictor (
    .clk(clk), .rst_n(rst_n), .priv_mode(priv_mode), .call_valid(call_valid),
    .ret_valid(ret_valid), .ret_kind(ret_kind), .link_pc(link_pc),
    .pred_valid(pred_valid), .pred_pc(pred_pc), .res_valid(res_valid),
    .res_pc(res_pc), .mispredict(mispredict), .tag_we(tag_we),
    .tag_idx(tag_idx), .tag_data(tag_data)
  );

  function automatic logic [29:0] tagf(int i);
    return 30'((i * 7919 + 1234567) ^ (i << 17));
  endfunction

  function automatic logic [42:0] mk_link(int idx, int salt);
    return {30'(salt * 977 + 3), 8'(idx), 5'(salt | 1)};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit c, bit r, logic [1:0] k, logic [42:0] lk, bit pv,
                      bit rv, logic [42:0] rp, string req);
    logic [7:0]  ei;
    logic [42:0] epc;
    bit          emm;
    @(negedge clk);
    call_valid = c; ret_valid = r; ret_kind = k; link_pc = lk;
    priv_mode = pv; res_valid = rv; res_pc = rp;
    #1;
    ei  = mstk[(msp + 11) % 12];
    epc = {ttag[ei], ei, 5'd0};
    if (r) begin
      chk(pred_valid == !pv, req, 64'(pred_valid), 64'(!pv));
      if (!pv) begin
        chk(pred_pc == epc, req, 64'(pred_pc), 64'(epc));
        last_exp = epc;
      end
    end else begin
      chk(pred_valid == 1'b0, req, 64'(pred_valid), 64'd0);
    end
    emm = rv && (!hv || hpc != rp);
    @(posedge clk);
    if (r) begin hv = !pv; hpc = epc; end
    if (!pv) begin
      if (r) msp = (msp + 11) % 12;
      if (c || (r && k == 2'd1)) begin
        mstk[msp] = lk[12:5];
        msp = (msp + 1) % 12;
      end
    end
    #1;
    chk(mispredict == emm, rv ? "R8 resolution" : "R8 no resolution", 64'(mispredict), 64'(emm));
  endtask

  task automatic idle();
    @(negedge clk);
    call_valid = 0; ret_valid = 0; res_valid = 0; priv_mode = 0; tag_we = 0;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 12; i++) mstk[i] = 8'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(pred_valid == 0, "R1 reset pred_valid", 64'(pred_valid), 64'd0);
    chk(mispredict == 0, "R1 reset mispredict", 64'(mispredict), 64'd0);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      tag_we = 1; tag_idx = 8'(i); tag_data = tagf(i); ttag[i] = tagf(i);
    end
    idle();
    // R1: return straight after reset predicts slot value 0
    step(0, 1, 2'd0, '0, 0, 0, '0, "R1 empty return");
    chk(last_exp == {ttag[0], 8'd0, 5'd0}, "R1 reset value", 64'(last_exp), 64'({ttag[0], 13'd0}));
    // R3 / R2: LIFO at every depth, cycling kinds 0, 2, 3
    for (int n = 1; n <= 12; n++) begin
      for (int j = 0; j < n; j++) step(1, 0, 2'd0, mk_link((n * 16 + j) & 255, j), 0, 0, '0, "R3 push");
      for (int j = 0; j < n; j++) begin
        step(0, 1, (j % 3 == 0) ? 2'd0 : ((j % 3 == 1) ? 2'd2 : 2'd3), '0, 0, 0, '0, "R2 R3 pop");
        chk(last_exp[12:5] == 8'((n * 16 + n - 1 - j) & 255), "R3 lifo order",
            64'(last_exp[12:5]), 64'((n * 16 + n - 1 - j) & 255));
      end
    end
    // R4: overflow then underflow
    for (int j = 0; j < 20; j++) step(1, 0, 2'd0, mk_link(200 + j, j), 0, 0, '0, "R4 overflow push");
    for (int j = 0; j < 14; j++) begin
      step(0, 1, 2'd0, '0, 0, 0, '0, "R4 pop");
      if (j < 12) chk(last_exp[12:5] == 8'(219 - j), "R4 newest twelve", 64'(last_exp[12:5]), 64'(219 - j));
    end
    chk(last_exp[12:5] == 8'(218), "R4 stale underflow", 64'(last_exp[12:5]), 64'd218);
    // R5: coroutine
    step(1, 0, 2'd0, mk_link(11, 1), 0, 0, '0, "R5 setup");
    step(1, 0, 2'd0, mk_link(22, 2), 0, 0, '0, "R5 setup");
    step(0, 1, 2'd1, mk_link(33, 3), 0, 0, '0, "R5 coroutine");
    chk(last_exp[12:5] == 8'd22, "R5 coroutine target", 64'(last_exp[12:5]), 64'd22);
    step(0, 1, 2'd0, '0, 0, 0, '0, "R5 after");
    chk(last_exp[12:5] == 8'd33, "R5 replaced top", 64'(last_exp[12:5]), 64'd33);
    step(0, 1, 2'd0, '0, 0, 0, '0, "R5 below");
    chk(last_exp[12:5] == 8'd11, "R5 depth kept", 64'(last_exp[12:5]), 64'd11);
    // R6: call and return together
    step(1, 0, 2'd0, mk_link(44, 4), 0, 0, '0, "R6 setup");
    step(1, 1, 2'd0, mk_link(55, 5), 0, 0, '0, "R6 same cycle");
    chk(last_exp[12:5] == 8'd44, "R6 old top", 64'(last_exp[12:5]), 64'd44);
    step(0, 1, 2'd0, '0, 0, 0, '0, "R6 after");
    chk(last_exp[12:5] == 8'd55, "R6 new top", 64'(last_exp[12:5]), 64'd55);
    // R7 / R9: privileged mode
    step(1, 0, 2'd0, mk_link(66, 6), 0, 0, '0, "R7 setup");
    step(1, 0, 2'd0, mk_link(77, 7), 1, 0, '0, "R7 priv call");
    step(0, 1, 2'd0, '0, 1, 0, '0, "R7 priv return");
    step(0, 0, 2'd0, '0, 0, 1, {ttag[66], 8'd66, 5'd0}, "R9 priv resolve");
    chk(mispredict == 1, "R9 priv mispredict", 64'(mispredict), 64'd1);
    step(0, 1, 2'd0, '0, 0, 0, '0, "R7 stack intact");
    chk(last_exp[12:5] == 8'd66, "R7 stack intact", 64'(last_exp[12:5]), 64'd66);
    // R8: matching and mismatching resolutions
    step(0, 0, 2'd0, '0, 0, 1, last_exp, "R8 match");
    chk(mispredict == 0, "R8 match", 64'(mispredict), 64'd0);
    step(0, 0, 2'd0, '0, 0, 1, last_exp + 43'd32, "R8 mismatch");
    chk(mispredict == 1, "R8 mismatch", 64'(mispredict), 64'd1);
    step(0, 0, 2'd0, '0, 0, 0, '0, "R8 pulse ends");
    // R10: tag rewrite
    step(1, 0, 2'd0, mk_link(90, 9), 0, 0, '0, "R10 setup");
    @(negedge clk);
    tag_we = 1; tag_idx = 8'd90; tag_data = tagf(90) ^ 30'h2AAAAAAA; ttag[90] = tagf(90) ^ 30'h2AAAAAAA;
    idle();
    step(0, 1, 2'd2, '0, 0, 0, '0, "R10 new tag");
    chk(last_exp[42:13] == (tagf(90) ^ 30'h2AAAAAAA), "R10 tag used",
        64'(last_exp[42:13]), 64'(tagf(90) ^ 30'h2AAAAAAA));
    idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule